// File: doc/BRIEF.md
# Digital I/O Register File with Change-of-State Interrupt

This block is the register file of a 56-line digital I/O function. It holds three byte-wide banks of output latches (24 lines), samples three byte-wide banks of isolated input lines (24 lines), and owns an 8-line TTL port. A control bit decides whether the TTL port drives its own latch or acts as an input. All 32 input lines pass through a synchroniser and then through per-bank edge detectors. Each detector sets sticky change-of-state status bits. Any set status bit holds the single level-sensitive interrupt line high until software clears the bit by writing a one to it.

The host reaches the 16 byte registers through a synchronous 32-bit register bus. The bus uses a word address and four byte enables, so one access covers four consecutive byte registers. Byte lane i of word w is byte offset 4w+i, carried on data bits 8i+7:8i. There is no back-pressure. A request is accepted in every cycle in which `req_valid` is high. A read answers exactly one cycle later with `rsp_valid` and `rsp_rdata`. A write produces no response. Writing any value to byte offset 15 resets the register state of the block. Reading offset 15 returns the interrupt level.

Top module: `dio_regfile`

## Requirements
- R1: After `rst_n` is released, `fet_out`, `ttl_out`, `ttl_oe` and `irq` are all zero.
- R2: Word 0 holds the output latches: lane 0..2 are lines 0-7, 8-15, 16-23 and lane 3 is the TTL latch. A write updates only the lanes whose byte enable is set. A read returns the latched values, and `fet_out`/`ttl_out` show them one cycle after the write.
- R3: Word 1 is read-only: lanes 0..2 return the synchronised isolated banks and lane 3 returns the synchronised TTL pins. Writes to word 1 change no state.
- R4: Bit 1 of the control byte (word 3, lane 0) drives `ttl_oe`. When it is 1 the TTL port drives the TTL latch. When it is 0 the port is an input.
- R5: The enable byte (word 3, lane 2) has a rising-edge enable at bit n and a falling-edge enable at bit n+4 for bank n. Banks 0..2 are the isolated banks and bank 3 is TTL. An edge of a synchronised line sets its status bit only if that edge type is enabled for its bank, and both types may be enabled together.
- R6: Status bits (word 2, lane n = bank n) are sticky. `irq` is high exactly while any status bit is set.
- R7: Writing ones to a status lane clears those bits, and a 32-bit write clears all four banks at once. Zero bits and disabled lanes leave status unchanged.
- R8: If an enabled edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: A write with lane 3 of word 3 enabled clears all latches, the control bit, the enable byte and all status bits. It takes priority over any other lane of the same access.
- R10: A read of word 3 returns the control byte in lane 0 with only bit 1 implemented, zero in lane 1, the enable byte in lane 2, and the interrupt level in bit 0 of lane 3. Writes to lane 1 have no effect.
- R11: A read request gives `rsp_valid` high for exactly one cycle, one cycle later, with the data sampled in the request cycle. Writes and idle cycles give `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word address (four byte registers per word) |
| req_be | input | 4 | Byte enables, lane i = bits 8i+7:8i |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data |
| iso_in | input | 24 | Isolated input lines (asynchronous) |
| ttl_in | input | 8 | TTL pad levels (asynchronous) |
| fet_out | output | 24 | Output latch lines |
| ttl_out | output | 8 | TTL output latch |
| ttl_oe | output | 1 | TTL port drive enable |
| irq | output | 1 | Level interrupt, OR of all status bits |

## Verification
An edge event from the detectors and a software write-one-to-clear can update the same status bit in the same cycle. The bench provokes this by moving an isolated input at a known falling clock edge. It counts the two synchroniser flops and the edge register, then issues the clearing write so that the bus samples it on the very edge where the event registers. The clear mask covers that bit and a neighbouring set bit. The outcome is judged by reading back the status byte: the bit hit by the event must survive and the neighbour must be cleared.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int BANK_W    = 8;
  localparam int ISO_BANKS = 3;
  localparam int COS_BANKS = ISO_BANKS + 1;
  localparam int ISO_W     = ISO_BANKS * BANK_W;
  localparam int IN_W      = COS_BANKS * BANK_W;
  localparam int LANES     = 4;
  localparam int DATA_W    = LANES * BANK_W;
  localparam int ADDR_W    = 2;

  // word indices
  localparam logic [ADDR_W-1:0] W_OUT = 2'd0;
  localparam logic [ADDR_W-1:0] W_IN  = 2'd1;
  localparam logic [ADDR_W-1:0] W_COS = 2'd2;
  localparam logic [ADDR_W-1:0] W_CTL = 2'd3;

  // lanes inside the control word
  localparam int LN_CTL  = 0;
  localparam int LN_RSVD = 1;
  localparam int LN_EN   = 2;
  localparam int LN_RST  = 3;

  localparam int CTL_OE_BIT = 1;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dio_cos_bank.sv
module dio_cos_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] din,
  input  logic         rise_en,
  input  logic         fall_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [W-1:0] prev;
  logic [W-1:0] ev;

  always_comb begin
    ev = '0;
    if (rise_en) ev = ev | (din & ~prev);
    if (fall_en) ev = ev | (~din & prev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= '0;
      status <= '0;
    end else begin
      prev <= din;
      // board reset wins, then a fresh event beats a clear of the same bit (R8)
      if (soft_rst) status <= '0;
      else          status <= (status & ~clr) | ev;
    end
  end
endmodule

// File: rtl/dio_regfile.sv
module dio_regfile
  import dio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [ISO_W-1:0]  iso_in,
  input  logic [BANK_W-1:0] ttl_in,
  output logic [ISO_W-1:0]  fet_out,
  output logic [BANK_W-1:0] ttl_out,
  output logic              ttl_oe,
  output logic              irq
);
  logic wr, rd, soft_rst;
  logic [BANK_W-1:0] out_q [LANES];
  logic              oe_q;
  logic [BANK_W-1:0] en_q;
  logic [IN_W-1:0]   in_s;
  logic [IN_W-1:0]   status_w;
  logic [DATA_W-1:0] rd_word;

  assign wr       = req_valid & req_write;
  assign rd       = req_valid & ~req_write;
  assign soft_rst = wr && (req_addr == W_CTL) && req_be[LN_RST];

  // output latches, R2 / R9
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) out_q[i] <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < LANES; i++) out_q[i] <= '0;
    end else if (wr && req_addr == W_OUT) begin
      for (int i = 0; i < LANES; i++)
        if (req_be[i]) out_q[i] <= req_wdata[i*BANK_W +: BANK_W];
    end
  end

  // control bit and edge enables, R4 / R5 / R9
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      en_q <= '0;
    end else if (soft_rst) begin
      oe_q <= 1'b0;
      en_q <= '0;
    end else if (wr && req_addr == W_CTL) begin
      if (req_be[LN_CTL]) oe_q <= req_wdata[LN_CTL*BANK_W + CTL_OE_BIT];
      if (req_be[LN_EN])  en_q <= req_wdata[LN_EN*BANK_W +: BANK_W];
    end
  end

  generate
    for (genvar g = 0; g < ISO_BANKS; g++) begin : g_fet
      assign fet_out[g*BANK_W +: BANK_W] = out_q[g];
    end
  endgenerate
  assign ttl_out = out_q[LANES-1];
  assign ttl_oe  = oe_q;

  dio_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ttl_in, iso_in}),
    .q     (in_s)
  );

  generate
    for (genvar b = 0; b < COS_BANKS; b++) begin : g_cos
      logic [BANK_W-1:0] clr_b;
      assign clr_b = (wr && req_addr == W_COS && req_be[b])
                     ? req_wdata[b*BANK_W +: BANK_W] : '0;
      dio_cos_bank #(.W(BANK_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .din      (in_s[b*BANK_W +: BANK_W]),
        .rise_en  (en_q[b]),
        .fall_en  (en_q[b + COS_BANKS]),
        .clr      (clr_b),
        .status   (status_w[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

  assign irq = |status_w;

  // read mux, R3 / R10
  always_comb begin
    rd_word = '0;
    case (req_addr)
      W_OUT: for (int i = 0; i < LANES; i++) rd_word[i*BANK_W +: BANK_W] = out_q[i];
      W_IN:  rd_word = in_s;
      W_COS: rd_word = status_w;
      default: begin
        rd_word[LN_CTL*BANK_W + CTL_OE_BIT] = oe_q;
        rd_word[LN_EN*BANK_W +: BANK_W]     = en_q;
        rd_word[LN_RST*BANK_W]              = irq;
      end
    endcase
  end

  // one-cycle read response, R11
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/dio_regfile_chk.sv
module dio_regfile_chk
  import dio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LANES-1:0]  req_be,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [ISO_W-1:0]  fet_out,
  input logic [BANK_W-1:0] ttl_out,
  input logic              ttl_oe,
  input logic              irq
);
  logic wr;
  assign wr = req_valid & req_write;

  p_rsp_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_no_rsp_otherwise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_fet_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == W_OUT && req_be[0]) |=> fet_out[BANK_W-1:0] == $past(req_wdata[BANK_W-1:0]));

  p_inputs_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == W_IN) |=> ($stable(fet_out) && $stable(ttl_out) && $stable(ttl_oe)));

  p_oe_follows_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == W_CTL && req_be[LN_CTL] && !req_be[LN_RST])
      |=> ttl_oe == $past(req_wdata[LN_CTL*BANK_W + CTL_OE_BIT]));

  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr) |=> irq);

  p_board_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == W_CTL && req_be[LN_RST])
      |=> (fet_out == '0 && ttl_out == '0 && !ttl_oe && !irq));
endmodule

bind dio_regfile dio_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_be    (req_be),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .fet_out   (fet_out),
  .ttl_out   (ttl_out),
  .ttl_oe    (ttl_oe),
  .irq       (irq)
);

// File: tb/sim_dio_regfile.sv
module sim_dio_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [23:0] iso_in = 24'hA53C81;
  logic [7:0]  ttl_in = 8'h5A;
  logic [23:0] fet_out;
  logic [7:0]  ttl_out;
  logic        ttl_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dio_regfile u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .iso_in(iso_in), .ttl_in(ttl_in),
    .fet_out(fet_out), .ttl_out(ttl_out), .ttl_oe(ttl_oe), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 4'hF, 32'h11223344, 32'h0},        // R2 full word
    '{1'b0, 2'd0, 4'hF, 32'h0,        32'h11223344}, // R2
    '{1'b1, 2'd0, 4'h5, 32'hAABBCCDD, 32'h0},        // R2 partial lanes
    '{1'b0, 2'd0, 4'hF, 32'h0,        32'h11BB33DD}, // R2
    '{1'b1, 2'd1, 4'hF, 32'hFFFFFFFF, 32'h0},        // R3 ignored write
    '{1'b0, 2'd1, 4'hF, 32'h0,        32'h5AA53C81}, // R3 inputs
    '{1'b1, 2'd3, 4'h5, 32'h000000FF, 32'h0},        // R4 ctl=FF, en=0
    '{1'b0, 2'd3, 4'hF, 32'h0,        32'h00000002}, // R10 only bit 1
    '{1'b1, 2'd3, 4'h2, 32'h0000FF00, 32'h0},        // R10 reserved lane
    '{1'b0, 2'd3, 4'hF, 32'h0,        32'h00000002}  // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R11 no response to write", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 response valid", {31'b0, rsp_valid}, 32'h1);
    d = rsp_rdata;
    @(negedge clk);
    chk("R11 single-cycle response", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rdv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fet_out", {8'h0, fet_out}, 32'h0);
    chk("R1 ttl_out", {24'h0, ttl_out}, 32'h0);
    chk("R1 ttl_oe", {31'h0, ttl_oe}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    settle();

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].be, VEC[i].data);
      else begin
        bus_read(VEC[i].addr, rdv);
        chk($sformatf("R2/R3/R10 vector %0d", i), rdv, VEC[i].exp);
      end
    end
    chk("R2 fet_out pins", {8'h0, fet_out}, 32'h00BB33DD);
    chk("R2 ttl_out pins", {24'h0, ttl_out}, 32'h11);
    chk("R4 ttl_oe set", {31'h0, ttl_oe}, 32'h1);
    chk("R1 no status yet", {31'h0, irq}, 32'h0);

    // R5 rising enable for bank 1 only
    bus_write(2'd3, 4'h4, 32'h00020000);
    @(negedge clk); iso_in[8] = 1'b1; iso_in[0] = 1'b0;
    settle();
    bus_read(2'd2, rdv);
    chk("R5 bank1 rise only", rdv, 32'h00000100);
    chk("R6 irq high", {31'h0, irq}, 32'h1);
    @(negedge clk); iso_in[8] = 1'b0;
    settle();
    bus_read(2'd2, rdv);
    chk("R5 disabled fall ignored / R6 sticky", rdv, 32'h00000100);

    // R5 falling enable for TTL bank (bit 7)
    bus_write(2'd3, 4'h4, 32'h00820000);
    @(negedge clk); ttl_in = 8'h58;
    settle();
    bus_read(2'd2, rdv);
    chk("R5 ttl fall", rdv, 32'h02000100);
    bus_read(2'd3, rdv);
    chk("R10 control word with irq", rdv, 32'h01820002);

    // R7 clear all four banks at once
    bus_write(2'd2, 4'hF, 32'hFFFFFFFF);
    bus_read(2'd2, rdv);
    chk("R7 full clear", rdv, 32'h0);
    chk("R6 irq low after clear", {31'h0, irq}, 32'h0);

    // R8 set beats clear in the same cycle
    bus_write(2'd3, 4'h4, 32'h00FF0000);
    @(negedge clk); iso_in[1:0] = 2'b11;
    settle();
    bus_read(2'd2, rdv);
    chk("R5 both edges enabled", rdv, 32'h00000003);
    @(negedge clk); iso_in[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    bus_write(2'd2, 4'h1, 32'h00000003);
    bus_read(2'd2, rdv);
    chk("R8 set wins over clear", rdv, 32'h00000001);

    // R9 board reset beats an enable write in the same access
    bus_write(2'd3, 4'hC, 32'hFFFF0000);
    chk("R9 fet_out cleared", {8'h0, fet_out}, 32'h0);
    chk("R9 ttl_out cleared", {24'h0, ttl_out}, 32'h0);
    chk("R9 ttl_oe cleared", {31'h0, ttl_oe}, 32'h0);
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);
    bus_read(2'd3, rdv);
    chk("R9 control word cleared", rdv, 32'h0);
    @(negedge clk); iso_in[23:16] = ~iso_in[23:16];
    settle();
    bus_read(2'd2, rdv);
    chk("R9 enables cleared", rdv, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule